// File: doc/BRIEF.md
# I2C Master Host Register and FIFO Frontend

This block is the host-facing side of a host-driven I2C master. It holds the configuration, bus-speed, FIFO-control, command and interrupt registers, plus a transmit byte queue and a receive byte queue. A single-cycle register bus carries host accesses. Software loads the target address byte (7-bit address shifted left by one, read/write flag in bit 0) and any write bytes into the transmit queue, then writes the command register with its launch bit set.

A separate bus sequencer, which drives the I2C pins, sees a narrow handshake. It gets a one-cycle start pulse with the latched protocol code, checksum-enable flag and read byte count. It pops transmit entries, each a byte plus a final-byte flag, and pushes receive entries, each a byte, a 2-bit status and a checksum-error flag. It reports the end of a transfer with a done pulse and a 3-bit result code. The launch bit reads as busy until the transfer ends. Its falling edge raises a sticky interrupt status bit that software clears by writing a one. The interrupt line is the OR of the status bits that are enabled.

Top module: `i2c_regbank`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `txValid` is low and the receive count (offset 0x0C, bits 22:16) is zero.
- R2: Offset 0x04 bit 31 drives `fastMode` (1 = 400 kHz, 0 = 100 kHz). Offset 0x00 bit 30 drives `ctlEnable`.
- R3: A write to offset 0x40 queues {bit 31 = final-byte flag, bits 7:0 = byte}. The sequencer sees entries in write order on `txByte`/`txLast` while `txValid` is high, and `txPop` removes the head. A write into a full queue (64 entries) is dropped.
- R4: A read of offset 0x44 returns the oldest receive entry, with the byte in bits 7:0, the status in bits 31:30 and the checksum-error flag in bit 29, and removes it. Entries come out in push order.
- R5: A read of offset 0x44 while the receive queue is empty returns zero and leaves the count at zero.
- R6: Writing offset 0x0C with bit 31 set empties the receive queue, and with bit 30 set empties the transmit queue, both in that same cycle. Bits 13:8 hold the receive threshold and read back.
- R7: A write to offset 0x30 with bit 31 set while idle sets busy (bit 31 reads 1). It emits a one-cycle `seqStart` and latches the protocol code (bits 12:9), checksum enable (bit 8) and read count (bits 7:0) onto the sequencer outputs. Command writes while busy are ignored.
- R8: `seqDone` while busy clears busy, stores `seqStatus` in offset 0x30 bits 27:25, and sets interrupt status bit 28 (offset 0x3C).
- R9: Interrupt status bits are write-one-to-clear. Writing a zero leaves a bit as it is.
- R10: `irq` is high exactly when some status bit (31, 30, 28) is set and the same bit is set in the enable register at offset 0x38.
- R11: Interrupt status bit 31 sets when the receive queue holds 64 entries. A sequencer push into a full receive queue is dropped.
- R12: Interrupt status bit 30 sets when the threshold is nonzero and the receive count is at least the threshold.
- R13: While offset 0x00 bit 31 is set, both queues are emptied and busy, command status and interrupt status are cleared. The speed selection is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive port) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, same cycle |
| ctlEnable | output | 1 | Controller enable to the sequencer |
| fastMode | output | 1 | 1 selects 400 kHz, 0 selects 100 kHz |
| seqStart | output | 1 | One-cycle transfer launch |
| seqProto | output | 4 | Latched protocol code |
| seqPecEn | output | 1 | Latched checksum enable |
| seqRdCnt | output | 8 | Latched read byte count |
| txValid | output | 1 | Transmit queue not empty |
| txByte | output | 8 | Transmit head byte |
| txLast | output | 1 | Transmit head is the final byte |
| txPop | input | 1 | Sequencer removes the transmit head |
| rxPush | input | 1 | Sequencer adds a receive entry |
| rxByte | input | 8 | Received byte |
| rxStat | input | 2 | Per-byte receive status |
| rxPecErr | input | 1 | Per-byte checksum error |
| seqDone | input | 1 | Transfer finished |
| seqStatus | input | 3 | Result code of the finished transfer |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue pointer or count shows at the ports within one access. A read of 0x44 returns a byte out of order or a stale value, and the count field at 0x0C disagrees with the number of pushes minus pops. A stuck or mis-cleared busy bit shows at once as a missing or repeated `seqStart`, a command read with bit 31 wrong, or interrupt bit 28 and `irq` not following on the cycle after `seqDone`. Sticky status errors appear as `irq` failing to follow the enable mask, or as a bit that survives a write-one or is lost on a write-zero.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;
  localparam logic [7:0] OFF_CFG  = 8'h00;
  localparam logic [7:0] OFF_TIM  = 8'h04;
  localparam logic [7:0] OFF_FCTL = 8'h0C;
  localparam logic [7:0] OFF_CMD  = 8'h30;
  localparam logic [7:0] OFF_IE   = 8'h38;
  localparam logic [7:0] OFF_IS   = 8'h3C;
  localparam logic [7:0] OFF_TX   = 8'h40;
  localparam logic [7:0] OFF_RX   = 8'h44;

  localparam int TX_W = 9;   // {last, byte}
  localparam int RX_W = 11;  // {stat[1:0], pecErr, byte}

  typedef struct packed {
    logic txPush;
    logic txFlush;
    logic rxPop;
    logic rxFlush;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_regbank_fifo.sv
module i2c_regbank_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [$clog2(DEPTH):0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign pushOk = push && !full && !flush;
  assign popOk  = pop && !empty && !flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end
endmodule

// File: rtl/i2c_regbank_dp.sv
module i2c_regbank_dp
  import i2c_regbank_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic [TX_W-1:0]        txWord,
  input  logic                   txPop,
  output logic [TX_W-1:0]        txHead,
  output logic                   txValid,
  output logic [$clog2(DEPTH):0] txCount,
  input  logic                   rxPush,
  input  logic [RX_W-1:0]        rxWord,
  output logic [RX_W-1:0]        rxHead,
  output logic [$clog2(DEPTH):0] rxCount
);
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic [RX_W-1:0] rxRaw;

  i2c_regbank_fifo #(.WIDTH(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .flush(stb.txFlush),
    .push(stb.txPush), .pushData(txWord), .pop(txPop),
    .headData(txHead), .count(txCount), .empty(txEmpty), .full(txFull)
  );

  i2c_regbank_fifo #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(stb.rxFlush),
    .push(rxPush), .pushData(rxWord), .pop(stb.rxPop),
    .headData(rxRaw), .count(rxCount), .empty(rxEmpty), .full(rxFull)
  );

  assign txValid = !txEmpty;
  assign rxHead  = rxEmpty ? '0 : rxRaw;
endmodule

// File: rtl/i2c_regbank_ctrl.sv
module i2c_regbank_ctrl
  import i2c_regbank_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             regAddr,
  input  logic                   regWr,
  input  logic                   regRd,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  output dpStrobe_t              stb,
  input  logic [RX_W-1:0]        rxHead,
  input  logic [$clog2(DEPTH):0] rxCount,
  output logic                   ctlEnable,
  output logic                   fastMode,
  output logic                   softRst,
  output logic                   seqStart,
  output logic [3:0]             seqProto,
  output logic                   seqPecEn,
  output logic [7:0]             seqRdCnt,
  input  logic                   seqDone,
  input  logic [2:0]             seqStatus,
  output logic                   cmdBusy,
  output logic [2:0]             intStatus,
  output logic [2:0]             intEnable,
  output logic                   irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [5:0] rxThr;
  logic [2:0] cmdStat;
  logic       startCmd, busyFall;
  logic [2:0] setVec, clrVec;

  function automatic logic wrHit(input logic [7:0] off);
    return regWr && (regAddr == off);
  endfunction

  assign startCmd = wrHit(OFF_CMD) && regWdata[31] && !cmdBusy && !softRst;
  assign busyFall = cmdBusy && seqDone && !softRst;

  always_comb begin
    stb.txPush  = wrHit(OFF_TX) && !softRst;
    stb.txFlush = softRst || (wrHit(OFF_FCTL) && regWdata[30]);
    stb.rxFlush = softRst || (wrHit(OFF_FCTL) && regWdata[31]);
    stb.rxPop   = regRd && (regAddr == OFF_RX) && (rxCount != '0);
  end

  // status vector order: [2]=rx full (bit 31), [1]=threshold (bit 30), [0]=done (bit 28)
  assign setVec = {rxCount == CNT_W'(DEPTH),
                   (rxThr != '0) && (rxCount >= CNT_W'(rxThr)),
                   busyFall};
  assign clrVec = wrHit(OFF_IS) ? {regWdata[31], regWdata[30], regWdata[28]} : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst   <= 1'b0;
      ctlEnable <= 1'b0;
      fastMode  <= 1'b0;
      rxThr     <= '0;
      intEnable <= '0;
      intStatus <= '0;
      cmdBusy   <= 1'b0;
      cmdStat   <= '0;
      seqStart  <= 1'b0;
      seqProto  <= '0;
      seqPecEn  <= 1'b0;
      seqRdCnt  <= '0;
    end else begin
      if (wrHit(OFF_CFG)) begin
        softRst   <= regWdata[31];
        ctlEnable <= regWdata[30];
      end
      if (wrHit(OFF_TIM))  fastMode  <= regWdata[31];
      if (wrHit(OFF_FCTL)) rxThr     <= regWdata[13:8];
      if (wrHit(OFF_IE))   intEnable <= {regWdata[31], regWdata[30], regWdata[28]};

      seqStart <= startCmd;
      if (softRst) begin
        cmdBusy <= 1'b0;
        cmdStat <= '0;
      end else if (startCmd) begin
        cmdBusy  <= 1'b1;
        cmdStat  <= '0;
        seqProto <= regWdata[12:9];
        seqPecEn <= regWdata[8];
        seqRdCnt <= regWdata[7:0];
      end else if (busyFall) begin
        cmdBusy <= 1'b0;
        cmdStat <= seqStatus;
      end

      intStatus <= softRst ? 3'b000 : ((intStatus & ~clrVec) | setVec);
    end
  end

  assign irq = |(intStatus & intEnable);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFF_CFG:  regRdata = {softRst, ctlEnable, 30'd0};
      OFF_TIM:  regRdata = {fastMode, 31'd0};
      OFF_FCTL: begin
        regRdata[16 +: CNT_W] = rxCount;
        regRdata[13:8]        = rxThr;
      end
      OFF_CMD:  regRdata = {cmdBusy, 3'd0, cmdStat, 12'd0, seqProto, seqPecEn, seqRdCnt};
      OFF_IE:   regRdata = {intEnable[2:1], 1'b0, intEnable[0], 28'd0};
      OFF_IS:   regRdata = {intStatus[2:1], 1'b0, intStatus[0], 28'd0};
      OFF_RX:   regRdata = {rxHead[10:8], 21'd0, rxHead[7:0]};
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
  import i2c_regbank_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        ctlEnable,
  output logic        fastMode,
  output logic        seqStart,
  output logic [3:0]  seqProto,
  output logic        seqPecEn,
  output logic [7:0]  seqRdCnt,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txLast,
  input  logic        txPop,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  input  logic [1:0]  rxStat,
  input  logic        rxPecErr,
  input  logic        seqDone,
  input  logic [2:0]  seqStatus,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  dpStrobe_t       stb;
  logic [TX_W-1:0] txHead;
  logic [RX_W-1:0] rxHead;
  logic [CNT_W-1:0] txCount, rxCount;
  logic            softRst, cmdBusy;
  logic [2:0]      intStatus, intEnable;

  i2c_regbank_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .stb(stb), .rxHead(rxHead), .rxCount(rxCount),
    .ctlEnable(ctlEnable), .fastMode(fastMode), .softRst(softRst),
    .seqStart(seqStart), .seqProto(seqProto), .seqPecEn(seqPecEn),
    .seqRdCnt(seqRdCnt), .seqDone(seqDone), .seqStatus(seqStatus),
    .cmdBusy(cmdBusy), .intStatus(intStatus), .intEnable(intEnable),
    .irq(irq)
  );

  i2c_regbank_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txWord({regWdata[31], regWdata[7:0]}), .txPop(txPop),
    .txHead(txHead), .txValid(txValid), .txCount(txCount),
    .rxPush(rxPush), .rxWord({rxStat, rxPecErr, rxByte}),
    .rxHead(rxHead), .rxCount(rxCount)
  );

  assign txByte = txHead[7:0];
  assign txLast = txHead[8];
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   seqStart,
  input logic                   seqDone,
  input logic                   cmdBusy,
  input logic                   softRst,
  input logic [2:0]             intStatus,
  input logic [2:0]             intEnable,
  input logic                   irq,
  input logic                   rxFlushStb,
  input logic [$clog2(DEPTH):0] rxCount,
  input logic [$clog2(DEPTH):0] txCount
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> cmdBusy);
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);
  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && seqDone && !softRst) |=> (!cmdBusy && intStatus[0]));
  p_masked_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 3'b000) |-> !irq);
  p_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushStb |=> (rxCount == '0));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= CNT_W'(DEPTH)) && (txCount <= CNT_W'(DEPTH)));
  p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!cmdBusy && intStatus == 3'b000));
endmodule

bind i2c_regbank i2c_regbank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .seqStart(seqStart), .seqDone(seqDone),
  .cmdBusy(cmdBusy), .softRst(softRst), .intStatus(intStatus),
  .intEnable(intEnable), .irq(irq), .rxFlushStb(stb.rxFlush),
  .rxCount(rxCount), .txCount(txCount)
);

// File: tb/i2c_regbank_bench.sv
module i2c_regbank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        ctlEnable, fastMode, seqStart, seqPecEn, txValid, txLast, irq;
  logic [3:0]  seqProto;
  logic [7:0]  seqRdCnt, txByte;
  logic        txPop = 1'b0, rxPush = 1'b0, rxPecErr = 1'b0, seqDone = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [1:0]  rxStat = '0;
  logic [2:0]  seqStatus = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_regbank u_i2c_regbank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .ctlEnable(ctlEnable),
    .fastMode(fastMode), .seqStart(seqStart), .seqProto(seqProto),
    .seqPecEn(seqPecEn), .seqRdCnt(seqRdCnt), .txValid(txValid),
    .txByte(txByte), .txLast(txLast), .txPop(txPop), .rxPush(rxPush),
    .rxByte(rxByte), .rxStat(rxStat), .rxPecErr(rxPecErr),
    .seqDone(seqDone), .seqStatus(seqStatus), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #2 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic popTx();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b, input logic [1:0] s, input logic p);
    @(negedge clk); rxByte = b; rxStat = s; rxPecErr = p; rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdReg(8'h00, v); chk("R1 cfg", v, 0);
    rdReg(8'h30, v); chk("R1 cmd", v, 0);
    rdReg(8'h3C, v); chk("R1 status", v, 0);
    rdReg(8'h0C, v); chk("R1 fifo ctrl", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 txValid", txValid, 0);
  endtask

  task automatic t_cfg();
    wrReg(8'h04, 32'h8000_0000);
    chk("R2 fastMode", fastMode, 1);
    wrReg(8'h00, 32'h4000_0000);
    chk("R2 ctlEnable", ctlEnable, 1);
  endtask

  task automatic t_tx_order();
    wrReg(8'h40, 32'h0000_00A4);
    wrReg(8'h40, 32'h0000_0011);
    wrReg(8'h40, 32'h8000_0022);
    chk("R3 head addr byte", {txValid, txLast, txByte}, {1'b1, 1'b0, 8'hA4});
    popTx();
    chk("R3 second", {txValid, txLast, txByte}, {1'b1, 1'b0, 8'h11});
    popTx();
    chk("R3 last flag", {txValid, txLast, txByte}, {1'b1, 1'b1, 8'h22});
    popTx();
    chk("R3 drained", txValid, 0);
  endtask

  task automatic t_tx_full();
    int bad = 0;
    for (int i = 0; i < 65; i++) wrReg(8'h40, 32'(i + 8'h40));
    for (int i = 0; i < 64; i++) begin
      if (!txValid || txByte !== 8'(i + 8'h40)) bad++;
      popTx();
    end
    chk("R3 full order", bad, 0);
    chk("R3 extra write dropped", txValid, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    pushRx(8'h5A, 2'b01, 1'b0);
    pushRx(8'hC3, 2'b10, 1'b1);
    pushRx(8'h07, 2'b00, 1'b0);
    rdReg(8'h0C, v); chk("R6 rx count", v[22:16], 3);
    rdReg(8'h44, v); chk("R4 first", v, 32'h4000_005A);
    rdReg(8'h44, v); chk("R4 second", v, 32'hA000_00C3);
    rdReg(8'h44, v); chk("R4 third", v, 32'h0000_0007);
    rdReg(8'h44, v); chk("R5 empty pop data", v, 0);
    rdReg(8'h0C, v); chk("R5 empty count", v[22:16], 0);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    wrReg(8'h0C, 32'h0000_0200);
    rdReg(8'h0C, v); chk("R6 threshold readback", v[13:8], 2);
    pushRx(8'h01, 2'b00, 1'b0);
    rdReg(8'h3C, v); chk("R12 below threshold", v[30], 0);
    pushRx(8'h02, 2'b00, 1'b0);
    rdReg(8'h3C, v); chk("R12 at threshold", v[30], 1);
    rdReg(8'h44, v);
    rdReg(8'h44, v);
    wrReg(8'h3C, 32'h0000_0000);
    rdReg(8'h3C, v); chk("R9 write zero keeps", v[30], 1);
    wrReg(8'h3C, 32'h4000_0000);
    rdReg(8'h3C, v); chk("R9 write one clears", v[30], 0);
  endtask

  task automatic t_rx_full();
    logic [31:0] v;
    for (int i = 0; i < 65; i++) pushRx(8'(i), 2'b00, 1'b0);
    rdReg(8'h0C, v); chk("R11 count capped", v[22:16], 64);
    rdReg(8'h3C, v); chk("R11 full status", v[31], 1);
    rdReg(8'h44, v); chk("R11 oldest kept", v[7:0], 0);
    wrReg(8'h0C, 32'h8000_0200);
    rdReg(8'h0C, v); chk("R6 rx flush", v[22:16], 0);
    wrReg(8'h3C, 32'hC000_0000);
    rdReg(8'h3C, v); chk("R9 both cleared", v, 0);
    wrReg(8'h40, 32'h0000_0033);
    wrReg(8'h0C, 32'h4000_0200);
    chk("R6 tx flush", txValid, 0);
  endtask

  task automatic t_command();
    logic [31:0] v;
    wrReg(8'h30, 32'h8000_0000 | (32'h8 << 9) | 32'h100 | 32'h05);
    chk("R7 start pulse", seqStart, 1);
    chk("R7 fields", {seqProto, seqPecEn, seqRdCnt}, {4'h8, 1'b1, 8'h05});
    @(negedge clk);
    chk("R7 pulse one cycle", seqStart, 0);
    rdReg(8'h30, v); chk("R7 busy", v[31], 1);
    wrReg(8'h30, 32'h8000_0000 | (32'h7 << 9) | 32'h09);
    chk("R7 ignored while busy", {seqStart, seqProto, seqRdCnt}, {1'b0, 4'h8, 8'h05});
    @(negedge clk); seqStatus = 3'd3; seqDone = 1'b1;
    @(negedge clk); seqDone = 1'b0;
    rdReg(8'h30, v); chk("R8 busy cleared status", {v[31], v[27:25]}, {1'b0, 3'd3});
    rdReg(8'h3C, v); chk("R8 done status bit", v[28], 1);
    chk("R10 masked irq", irq, 0);
    wrReg(8'h38, 32'h1000_0000);
    chk("R10 enabled irq", irq, 1);
    wrReg(8'h3C, 32'h1000_0000);
    chk("R10 irq after clear", irq, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wrReg(8'h40, 32'h0000_0055);
    pushRx(8'h66, 2'b00, 1'b0);
    wrReg(8'h30, 32'h8000_0001);
    @(negedge clk); seqDone = 1'b1; seqStatus = 3'd0;
    @(negedge clk); seqDone = 1'b0;
    wrReg(8'h30, 32'h8000_0002);
    wrReg(8'h00, 32'hC000_0000);
    wrReg(8'h00, 32'h4000_0000);
    rdReg(8'h30, v); chk("R13 busy cleared", v[31], 0);
    rdReg(8'h3C, v); chk("R13 status cleared", v, 0);
    rdReg(8'h0C, v); chk("R13 rx emptied", v[22:16], 0);
    chk("R13 tx emptied", txValid, 0);
    chk("R13 speed kept", fastMode, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_cfg();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_threshold();
    t_rx_full();
    t_command();
    t_soft_reset();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule